// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block conditions two active-low external interrupt pins before they reach an interrupt controller. Each source has a trigger-type bit. When the bit is set, the source latches a request on a falling edge of the pin. When the bit is clear, the request follows the live pin level. The pins are brought into the clock domain through a two-flop synchronizer. They are then sampled only on machine-cycle ticks, and a falling edge is a high sample followed by a low sample on consecutive ticks.

The controller gives the block two strobes per source. An acknowledge strobe marks the entry into that source's handler. A return strobe marks the handler's exit. A latched edge request is blind to new edges while its handler runs, and it is cleared when the handler returns. In level mode nothing is latched, so a low pulse that ends before it is serviced is gone. Software reads and writes the type bits and the request flags through a small control field. A flag write takes effect in edge mode.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset both type bits and both edge flags are 0. With both pins high, `req_o` is 00 and `ctl_o` is 0000.
- R2: Control field layout: bit0 = type of source 0, bit1 = flag of source 0, bit2 = type of source 1, bit3 = flag of source 1. A write on `wr_en_i` loads both type bits in the next cycle. A type of 1 selects falling-edge mode and 0 selects low-level mode.
- R3: In edge mode a falling edge sets the source's flag and `req_o` bit. The edge is a high sample followed by a low sample on consecutive ticks. With `tick_i` held high, the request appears at the third rising clock edge after the pin falls.
- R4: In edge mode the flag stays set after the pin returns high.
- R5: In edge mode, a falling edge that arrives between an acknowledge strobe and the matching return strobe of that source does not set the flag.
- R6: A return strobe clears the edge flag of its source in the next cycle. It has priority over a flag write in the same cycle.
- R7: In level mode `req_o` and the flag bit read back show the last sampled pin level inverted. The request drops three cycles after the pin rises (tick held high), whether or not it was serviced.
- R8: In edge mode, writing a flag bit sets or clears that flag in the next cycle. In level mode, a flag write has no effect.
- R9: The pin is sampled only on cycles with `tick_i` high. A pin change during cycles without a tick is not seen until the next tick, and the request then changes one cycle after that tick.
- R10: The two sources are independent. Pins, strobes and modes of one never change the request of the other.
- R11: In edge mode, a pin held low after its flag is cleared does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Machine-cycle sample enable |
| pin_ni | input | 2 | Active-low external interrupt pins |
| ack_i | input | 2 | Handler-entry strobe, one per source |
| reti_i | input | 2 | Handler-return strobe, one per source |
| wr_en_i | input | 1 | Control field write enable |
| wr_data_i | input | 4 | Control field write data |
| req_o | output | 2 | Request to the interrupt controller |
| ctl_o | output | 4 | Control field read-back (flags show live request) |

## Verification
A pin change with `tick_i` held high passes two synchronizer flops and the sample register. Its effect on `req_o` is therefore due at the third rising edge after the pin moves. Strobes, control writes and an isolated tick all act one edge later. The scoreboard records every expected value with the absolute cycle in which it is due. Stimulus is applied just after a falling clock edge. The monitor compares the outputs at the falling edge of exactly that cycle. Some checks also fall one cycle before a request is due, to confirm that it does not appear early.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  // Per-source control slice; bit order is what software sees:
  // lower bit = trigger type, upper bit = request flag.
  typedef struct packed {
    logic flag;
    logic trig_edge;
  } chan_ctl_t;

  localparam int CTL_BITS = $bits(chan_ctl_t);

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] st_d;
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_comb begin
    st_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      st_d[s] = st_q[s-1];
    end
  end

  // Idle level of an active-low pin is high.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '1;
    end else begin
      st_q <= st_d;
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/irq_trig_chan.sv
module irq_trig_chan
  import irq_trig_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      pin_s_i,
  input  logic      ack_i,
  input  logic      reti_i,
  input  logic      wr_en_i,
  input  chan_ctl_t wr_ctl_i,
  output logic      req_o,
  output chan_ctl_t rd_ctl_o
);

  logic lvl_q,  lvl_d;
  logic busy_q, busy_d;
  logic flag_q, flag_d;
  logic type_q, type_d;
  logic fall_hit;

  always_comb begin
    // High sample followed by a low sample on consecutive ticks.
    fall_hit = tick_i & lvl_q & ~pin_s_i;
    lvl_d    = tick_i ? pin_s_i : lvl_q;

    type_d = wr_en_i ? wr_ctl_i.trig_edge : type_q;

    busy_d = busy_q;
    if (ack_i)  busy_d = 1'b1;
    if (reti_i) busy_d = 1'b0;

    flag_d = flag_q;
    if (fall_hit && !busy_q) flag_d = 1'b1;
    if (wr_en_i)             flag_d = wr_ctl_i.flag;
    if (reti_i)              flag_d = 1'b0;
    if (!type_d)             flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      busy_q <= 1'b0;
      flag_q <= 1'b0;
      type_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      busy_q <= busy_d;
      flag_q <= flag_d;
      type_q <= type_d;
    end
  end

  always_comb begin
    req_o              = type_q ? flag_q : ~lvl_q;
    rd_ctl_o.trig_edge = type_q;
    rd_ctl_o.flag      = req_o;
  end

endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
  import irq_trig_pkg::*;
#(
  parameter  int NSRC        = 2,
  parameter  int SYNC_STAGES = 2,
  parameter  int RST_STAGES  = 2,
  localparam int CTL_W       = NSRC * CTL_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [NSRC-1:0]  pin_ni,
  input  logic [NSRC-1:0]  ack_i,
  input  logic [NSRC-1:0]  reti_i,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  output logic [NSRC-1:0]  req_o,
  output logic [CTL_W-1:0] ctl_o
);

  logic            rst_q_n;
  logic [NSRC-1:0] pin_s;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (rst_q_n)
  );

  irq_pin_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_q_n),
    .d_i   (pin_ni),
    .q_o   (pin_s)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_chan
    chan_ctl_t wr_slice;
    chan_ctl_t rd_slice;

    assign wr_slice = chan_ctl_t'(wr_data_i[k*CTL_BITS +: CTL_BITS]);

    irq_trig_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_q_n),
      .tick_i  (tick_i),
      .pin_s_i (pin_s[k]),
      .ack_i   (ack_i[k]),
      .reti_i  (reti_i[k]),
      .wr_en_i (wr_en_i),
      .wr_ctl_i(wr_slice),
      .req_o   (req_o[k]),
      .rd_ctl_o(rd_slice)
    );

    assign ctl_o[k*CTL_BITS +: CTL_BITS] = rd_slice;
  end

endmodule

// File: rtl/irq_trig_chk.sv
module irq_trig_chk #(
  parameter int NSRC  = 2,
  parameter int CTL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [NSRC-1:0]  ack_i,
  input logic [NSRC-1:0]  reti_i,
  input logic             wr_en_i,
  input logic [CTL_W-1:0] wr_data_i,
  input logic [NSRC-1:0]  req_o,
  input logic [CTL_W-1:0] ctl_o
);

  // Handler-running model built from the strobes alone.
  logic [NSRC-1:0] busy_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_m <= '0;
    end else begin
      busy_m <= (busy_m | ack_i) & ~reti_i;
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    // R2
    type_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> ctl_o[2*k] == $past(wr_data_i[2*k]));

    // R3
    edge_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(req_o[k]) && ctl_o[2*k] && !$past(wr_en_i)) |-> $past(tick_i));

    // R5
    busy_blocks_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_m[k] && ctl_o[2*k] && !req_o[k] && !wr_en_i) |=> !req_o[k]);

    // R6
    reti_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reti_i[k] && ctl_o[2*k] && !wr_en_i) |=> !req_o[k]);

    // R8
    flag_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_data_i[2*k] && wr_data_i[2*k+1] && !reti_i[k]) |=> req_o[k]);
  end

endmodule

bind ext_irq_trigger irq_trig_chk #(.NSRC(NSRC), .CTL_W(CTL_W)) u_irq_trig_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_q_n),
  .tick_i   (tick_i),
  .ack_i    (ack_i),
  .reti_i   (reti_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .req_o    (req_o),
  .ctl_o    (ctl_o)
);

// File: tb/test_ext_irq_trigger.sv
`timescale 1ns/1ps
module test_ext_irq_trigger;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [1:0] pin_n;
  logic [1:0] ack;
  logic [1:0] reti;
  logic       wr_en;
  logic [3:0] wr_data;
  logic [1:0] req;
  logic [3:0] ctl;

  int cyc    = 0;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ext_irq_trigger i_ext_irq_trigger (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .pin_ni   (pin_n),
    .ack_i    (ack),
    .reti_i   (reti),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .req_o    (req),
    .ctl_o    (ctl)
  );

  typedef struct {
    int         at;
    logic [1:0] req;
    logic [3:0] ctl;
    string      tag;
  } exp_t;

  exp_t sbq[$];

  task automatic expect_in(int d, logic [1:0] r, logic [3:0] c, string tag);
    exp_t e;
    e.at  = cyc + d;
    e.req = r;
    e.ctl = c;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // Monitor: compare items due in this cycle, away from the rising edge.
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at <= cyc) begin
        checks++;
        if (sbq[i].at < cyc || req !== sbq[i].req || ctl !== sbq[i].ctl) begin
          errors++;
          $display("FAIL %s @%0d: actual req=%b ctl=%b expected req=%b ctl=%b",
                   sbq[i].tag, cyc, req, ctl, sbq[i].req, sbq[i].ctl);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [3:0] v, logic [1:0] r, logic [3:0] c, string tag);
    expect_in(1, r, c, tag);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic pulse_ack(int k, logic [1:0] r, logic [3:0] c, string tag);
    expect_in(1, r, c, tag);
    ack[k] = 1'b1;
    @(negedge clk);
    ack = '0;
  endtask

  task automatic pulse_reti(int k, logic [1:0] r, logic [3:0] c, string tag);
    expect_in(1, r, c, tag);
    reti[k] = 1'b1;
    @(negedge clk);
    reti = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    tick    = 1'b1;
    pin_n   = 2'b11;
    ack     = '0;
    reti    = '0;
    wr_en   = 1'b0;
    wr_data = '0;
    step(4);
    rst_n = 1'b1;
    step(4);

    // R1: reset state
    expect_in(1, 2'b00, 4'b0000, "R1");
    step(1);

    // R2: both sources to edge mode
    reg_write(4'b0101, 2'b00, 4'b0101, "R2");

    // R3: falling edge on source 0, due on the third edge
    pin_n[0] = 1'b0;
    expect_in(2, 2'b00, 4'b0101, "R3");
    expect_in(3, 2'b01, 4'b0111, "R3");
    step(3);

    // R4: flag latched after pin returns high
    pin_n[0] = 1'b1;
    expect_in(5, 2'b01, 4'b0111, "R4");
    step(5);

    // R8: software clear and set in edge mode
    reg_write(4'b0101, 2'b00, 4'b0101, "R8");
    reg_write(4'b0111, 2'b01, 4'b0111, "R8");

    // R5: handler running, clear flag, new edge ignored
    pulse_ack(0, 2'b01, 4'b0111, "R5");
    reg_write(4'b0101, 2'b00, 4'b0101, "R8");
    pin_n[0] = 1'b0;
    expect_in(5, 2'b00, 4'b0101, "R5");
    step(5);
    pulse_reti(0, 2'b00, 4'b0101, "R6");
    pin_n[0] = 1'b1;
    step(4);
    pin_n[0] = 1'b0;
    expect_in(3, 2'b01, 4'b0111, "R3");
    step(3);

    // R6: return clears; R11: held-low pin does not re-trigger
    pulse_ack(0, 2'b01, 4'b0111, "R6");
    pulse_reti(0, 2'b00, 4'b0101, "R6");
    expect_in(6, 2'b00, 4'b0101, "R11");
    step(6);
    pin_n[0] = 1'b1;
    step(4);

    // R8: flag write ignored in level mode
    reg_write(4'b0000, 2'b00, 4'b0000, "R2");
    reg_write(4'b0010, 2'b00, 4'b0000, "R8");

    // R7: level follows the pin and is lost when the pin returns high
    pin_n[0] = 1'b0;
    expect_in(2, 2'b00, 4'b0000, "R7");
    expect_in(3, 2'b01, 4'b0010, "R7");
    step(3);
    pin_n[0] = 1'b1;
    expect_in(3, 2'b00, 4'b0000, "R7");
    step(3);

    // R9: no tick, no sampling
    tick = 1'b0;
    pin_n[0] = 1'b0;
    expect_in(6, 2'b00, 4'b0000, "R9");
    step(6);
    tick = 1'b1;
    expect_in(1, 2'b01, 4'b0010, "R9");
    step(1);
    tick = 1'b0;
    pin_n[0] = 1'b1;
    expect_in(5, 2'b01, 4'b0010, "R9");
    step(5);
    tick = 1'b1;
    expect_in(1, 2'b00, 4'b0000, "R9");
    step(1);

    // R10: source 1 edge, source 0 level, independent
    reg_write(4'b0100, 2'b00, 4'b0100, "R2");
    pin_n[1] = 1'b0;
    expect_in(3, 2'b10, 4'b1100, "R10");
    step(3);
    pin_n[0] = 1'b0;
    expect_in(3, 2'b11, 4'b1110, "R10");
    step(3);
    pulse_reti(0, 2'b11, 4'b1110, "R10");
    pulse_reti(1, 2'b01, 4'b0110, "R6");
    pin_n = 2'b11;
    expect_in(3, 2'b00, 4'b0100, "R10");
    step(4);

    step(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule